// File: doc/BRIEF.md
# MMC Data FIFO and Transfer Counter

This block sits between a host's data register and a byte-wide card data port. It holds up to 32 halfword entries. When data flows from the card to the host it packs incoming card bytes into halfwords, little-endian. When data flows the other way it splits queued halfwords into card bytes, low byte first. Software or a DMA engine reaches the FIFO through a single data register: a write pushes an entry and a read pops the head.

A per-block byte counter and a block counter follow the transfer. When a block length is odd, the last byte of each block travels alone, as the low half of an entry. When the last block finishes, the transfer ends and a completion pulse is raised. Two programmable levels watch the occupancy: a high-water level for receive and a low-water level for transmit. A configuration bit for each direction decides where a crossing is reported: on a DMA request line or on a status flag.

The command logic starts a transfer with a one-cycle start strobe and a direction bit. The card side uses a valid/ready handshake, one byte per accepted beat.

Top module: `mmc_xfer_fifo`

## Requirements
- R1: After reset the transfer is idle, the FIFO is empty, and every request, flag and card handshake output is low.
- R2: Host data writes (select 0) are kept in order, up to 32 entries. A write made while 32 entries are held is dropped. A data read pops the head. A data read made while the FIFO is empty returns the head entry without popping it.
- R3: Block length (select 1) and block count (select 2) take an 11-bit value v and store v+1. Writing the block count also reloads the byte counter from the stored block length.
- R4: In card-to-host transfers the first byte of a pair goes to bits 7:0 and the second to bits 15:8. If a block ends after the first byte, that entry is pushed with bits 15:8 zero.
- R5: In host-to-card transfers each entry sends its low byte and then its high byte. The high byte is skipped when the block ends after the low byte.
- R6: When the byte counter expires it reloads and the block counter decrements. When the last block's last byte is taken, xfer_done pulses for one cycle, xfer_active drops, and both counters reload.
- R7: The buffer configuration word (select 3) has these fields: bit 15 is the receive-DMA enable, bits 12:8 are the high-water level, bit 7 is the transmit-DMA enable and bits 4:0 are the low-water level. After reset the high-water level is 31 and the low-water level is 0.
- R8: In the card-to-host direction, an occupancy above the high-water level raises dma_rx_req if receive DMA is enabled and stat_rx_level if it is not.
- R9: In the host-to-card direction, an occupancy below the low-water level raises dma_tx_req if transmit DMA is enabled and stat_tx_level if it is not.
- R10: While no transfer is active and the FIFO is empty, both level flags and both DMA requests are low.
- R11: card_rx_ready is low while the occupancy is above the high-water level and no half-filled entry is pending.
- R12: A transfer start empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 data, 1 block length, 2 block count, 3 buffer config |
| reg_wr_data | input | 16 | Write data |
| data_rd_en | input | 1 | Data register read (pop) strobe |
| data_rd_data | output | 16 | Current head entry |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_dir | input | 1 | 1 card-to-host, 0 host-to-card |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| card_rx_valid | input | 1 | Card byte offered |
| card_rx_byte | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Byte offered to card |
| card_tx_byte | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts the byte |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| stat_rx_level | output | 1 | Receive level flag |
| stat_tx_level | output | 1 | Transmit level flag |

## Verification
A corrupted read pointer or occupancy count shows up on the next data read, as a wrong head value or a popped empty FIFO. It also shows up on the level outputs in the cycle after the bad update. A byte counter that is off by one moves both the zero-filled high byte of a packed entry and the xfer_done pulse by one card beat, so a stream of known length exposes it within one block. A lost pending-half flag swaps bytes in the next entry read by the host.

// File: rtl/mmc_fifo_pkg.sv
package mmc_fifo_pkg;
  typedef enum logic [1:0] {SEL_DATA = 2'd0, SEL_BLEN = 2'd1, SEL_NBLK = 2'd2, SEL_BUF = 2'd3} wr_sel_e;

  typedef struct packed {
    logic       rx_dma;
    logic [4:0] hi_lvl;
    logic       tx_dma;
    logic [4:0] lo_lvl;
  } bufcfg_t;

  function automatic bufcfg_t decode_bufcfg(input logic [15:0] w);
    bufcfg_t c;
    c.rx_dma = w[15];
    c.hi_lvl = w[12:8];
    c.tx_dma = w[7];
    c.lo_lvl = w[4:0];
    return c;
  endfunction

  function automatic logic [11:0] len_plus_one(input logic [10:0] v);
    return {1'b0, v} + 12'd1;
  endfunction

  function automatic logic [15:0] pack_pair(input logic [7:0] first, input logic [7:0] second);
    return {second, first};
  endfunction
endpackage

// File: rtl/xf_fifo_mem.sv
module xf_fifo_mem #(
  parameter int DW = 16,
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;

  assign wr_ptr = rd_ptr + count[PW-1:0];
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (count < CW'(DEPTH)));
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/xf_blk_count.sv
module xf_blk_count #(
  parameter int LENW = 11,
  localparam int CNTW = LENW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blen_wr,
  input  logic            nblk_wr,
  input  logic [LENW-1:0] wr_val,
  input  logic            byte_take,
  output logic            blk_end,
  output logic            xfer_end
);
  import mmc_fifo_pkg::*;
  logic [CNTW-1:0] blen, bcnt, nblk, ncnt;

  assign blk_end  = byte_take && (bcnt == CNTW'(1));
  assign xfer_end = blk_end && (ncnt == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen <= CNTW'(1);
      bcnt <= CNTW'(1);
      nblk <= CNTW'(1);
      ncnt <= CNTW'(1);
    end else if (blen_wr) begin
      blen <= len_plus_one(wr_val);
      bcnt <= len_plus_one(wr_val);
    end else if (nblk_wr) begin
      nblk <= len_plus_one(wr_val);
      ncnt <= len_plus_one(wr_val);
      bcnt <= blen;
    end else if (byte_take) begin
      if (bcnt == CNTW'(1)) begin
        bcnt <= blen;
        ncnt <= (ncnt == CNTW'(1)) ? nblk : ncnt - 1'b1;
      end else begin
        bcnt <= bcnt - 1'b1;
      end
    end
  end

  assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0) && (ncnt != '0));
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !blen_wr && !nblk_wr) |=> (ncnt == nblk) && (bcnt == blen));
endmodule

// File: rtl/xf_level.sv
module xf_level #(
  parameter int CW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  dir_rx,
  input  logic [CW-1:0]         count,
  input  mmc_fifo_pkg::bufcfg_t cfg,
  output logic                  dma_rx,
  output logic                  dma_tx,
  output logic                  st_rx,
  output logic                  st_tx
);
  logic gate, rx_hit, tx_hit;

  assign gate   = active || (count != '0);
  assign rx_hit = gate && dir_rx && (count > CW'(cfg.hi_lvl));
  assign tx_hit = gate && !dir_rx && (count < CW'(cfg.lo_lvl));
  assign dma_rx = rx_hit && cfg.rx_dma;
  assign st_rx  = rx_hit && !cfg.rx_dma;
  assign dma_tx = tx_hit && cfg.tx_dma;
  assign st_tx  = tx_hit && !cfg.tx_dma;

  assert_rx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n) !(dma_rx && st_rx));
  assert_tx_excl_R9: assert property (@(posedge clk) disable iff (!rst_n) !(dma_tx && st_tx));
  assert_dir_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((dma_rx || st_rx) && (dma_tx || st_tx)));
endmodule

// File: rtl/mmc_xfer_fifo.sv
module mmc_xfer_fifo #(
  parameter int DEPTH = 32,
  parameter int LENW = 11,
  localparam int DW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_wr_sel,
  input  logic [15:0] reg_wr_data,
  input  logic        data_rd_en,
  output logic [15:0] data_rd_data,
  input  logic        xfer_start,
  input  logic        xfer_dir,
  output logic        xfer_active,
  output logic        xfer_done,
  input  logic        card_rx_valid,
  input  logic [7:0]  card_rx_byte,
  output logic        card_rx_ready,
  output logic        card_tx_valid,
  output logic [7:0]  card_tx_byte,
  input  logic        card_tx_ready,
  output logic        dma_rx_req,
  output logic        dma_tx_req,
  output logic        stat_rx_level,
  output logic        stat_tx_level
);
  import mmc_fifo_pkg::*;

  logic          dir_rx, half_pend, tx_half;
  logic [7:0]    half_lo;
  bufcfg_t       cfg;
  logic [CW-1:0] count;
  logic [DW-1:0] head;
  logic          blk_end, xfer_end;
  logic          rx_take, rx_push, tx_take, tx_pop, byte_take;
  logic          host_push, host_pop, push, pop;
  logic [DW-1:0] rx_word, push_data;
  logic          wr_data, wr_blen, wr_nblk, wr_buf;
  logic          over_hi;

  assign wr_data = reg_wr_en && (reg_wr_sel == SEL_DATA);
  assign wr_blen = reg_wr_en && (reg_wr_sel == SEL_BLEN);
  assign wr_nblk = reg_wr_en && (reg_wr_sel == SEL_NBLK);
  assign wr_buf  = reg_wr_en && (reg_wr_sel == SEL_BUF);

  assign over_hi       = count > CW'(cfg.hi_lvl);
  assign card_rx_ready = xfer_active && dir_rx && (half_pend || !over_hi) && (count < CW'(DEPTH));
  assign rx_take       = card_rx_valid && card_rx_ready;
  assign rx_push       = rx_take && (half_pend || blk_end);
  assign rx_word       = half_pend ? pack_pair(half_lo, card_rx_byte) : pack_pair(card_rx_byte, 8'h00);

  assign card_tx_valid = xfer_active && !dir_rx && (count != '0);
  assign card_tx_byte  = tx_half ? head[15:8] : head[7:0];
  assign tx_take       = card_tx_valid && card_tx_ready;
  assign tx_pop        = tx_take && (tx_half || blk_end);

  assign byte_take = rx_take || tx_take;
  assign host_push = wr_data && (count != CW'(DEPTH)) && !rx_push;
  assign host_pop  = data_rd_en && (count != '0) && !tx_pop;
  assign push      = rx_push || host_push;
  assign pop       = tx_pop || host_pop;
  assign push_data = rx_push ? rx_word : reg_wr_data;

  assign data_rd_data = head;
  assign xfer_done    = xfer_end;

  xf_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .flush(xfer_start), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .count(count));

  xf_blk_count #(.LENW(LENW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .blen_wr(wr_blen), .nblk_wr(wr_nblk),
    .wr_val(reg_wr_data[LENW-1:0]), .byte_take(byte_take),
    .blk_end(blk_end), .xfer_end(xfer_end));

  xf_level #(.CW(CW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .active(xfer_active), .dir_rx(dir_rx), .count(count), .cfg(cfg),
    .dma_rx(dma_rx_req), .dma_tx(dma_tx_req), .st_rx(stat_rx_level), .st_tx(stat_tx_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_active <= 1'b0;
      dir_rx      <= 1'b0;
      half_pend   <= 1'b0;
      half_lo     <= '0;
      tx_half     <= 1'b0;
      cfg         <= '{rx_dma: 1'b0, hi_lvl: 5'd31, tx_dma: 1'b0, lo_lvl: 5'd0};
    end else begin
      if (wr_buf) cfg <= decode_bufcfg(reg_wr_data);
      if (xfer_start) begin
        xfer_active <= 1'b1;
        dir_rx      <= xfer_dir;
        half_pend   <= 1'b0;
        tx_half     <= 1'b0;
      end else begin
        if (xfer_end) xfer_active <= 1'b0;
        if (rx_take) begin
          if (half_pend || blk_end) begin
            half_pend <= 1'b0;
          end else begin
            half_pend <= 1'b1;
            half_lo   <= card_rx_byte;
          end
        end
        if (tx_take) tx_half <= !(tx_half || blk_end);
      end
    end
  end

  assert_rx_pause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_pend && over_hi) |-> !card_rx_ready);
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_start) |=> !xfer_active);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && (count == '0)) |-> !(dma_rx_req || dma_tx_req || stat_rx_level || stat_tx_level));
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready && !xfer_start && !data_rd_en) |=> $stable(card_tx_byte));
  assert_start_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (count == '0));
endmodule

// File: tb/mmc_xfer_fifo_test.sv
module mmc_xfer_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0, data_rd_en = 1'b0, xfer_start = 1'b0, xfer_dir = 1'b0;
  logic [1:0] reg_wr_sel = '0;
  logic [15:0] reg_wr_data = '0, data_rd_data;
  logic xfer_active, xfer_done, card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0] card_rx_byte = '0, card_tx_byte;
  logic card_tx_valid, card_tx_ready = 1'b0;
  logic dma_rx_req, dma_tx_req, stat_rx_level, stat_tx_level;

  int n_cmp = 0, n_bad = 0, done_cnt = 0, tx_seen = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  tx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_xfer_fifo uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: completion pulses and bytes handed to the card
  always @(posedge clk) begin
    if (rst_n && xfer_done) done_cnt++;
    if (rst_n && card_tx_valid && card_tx_ready) begin
      tx_seen++;
      if (tx_q.size() == 0) chk("R5 unexpected byte", {24'h0, card_tx_byte}, 32'hFFFF);
      else chk("R5 byte order", {24'h0, card_tx_byte}, {24'h0, tx_q.pop_front()});
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string req);
    logic [15:0] e;
    e = exp_q.pop_front();
    chk(req, {16'h0, data_rd_data}, {16'h0, e});
    data_rd_en = 1'b1;
    @(negedge clk);
    data_rd_en = 1'b0;
  endtask

  task automatic start(input logic dir);
    xfer_start = 1'b1; xfer_dir = dir;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    card_rx_valid = 1'b1; card_rx_byte = b;
    for (int i = 0; i < 20; i++) begin
      if (card_rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    card_rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", xfer_active, 0);
    chk("R1 outputs", {dma_rx_req, dma_tx_req, stat_rx_level, stat_tx_level, card_rx_ready, card_tx_valid}, 0);

    // R2 fill past full, drain in order, empty read
    for (int i = 0; i < 33; i++) begin
      wr(2'd0, 16'h1000 + 16'(i));
      if (i < 32) exp_q.push_back(16'h1000 + 16'(i));
    end
    for (int i = 0; i < 32; i++) pop_chk("R2 order");
    chk("R2 empty read head", {16'h0, data_rd_data}, 32'h1000);
    data_rd_en = 1'b1; @(negedge clk); data_rd_en = 1'b0;
    chk("R2 empty read no pop", {16'h0, data_rd_data}, 32'h1000);
    wr(2'd0, 16'hBEEF);
    exp_q.push_back(16'hBEEF);
    pop_chk("R2 after empty read");

    // R4/R6 two odd blocks card-to-host
    wr(2'd1, 16'd2); wr(2'd2, 16'd1);
    start(1'b1);
    chk("R6 active", xfer_active, 1);
    feed(8'h11); feed(8'h22); feed(8'h33); feed(8'h44); feed(8'h55);
    chk("R6 no early done", done_cnt, 0);
    feed(8'h66);
    chk("R6 done once", done_cnt, 1);
    chk("R6 idle after", xfer_active, 0);
    exp_q.push_back(16'h2211); exp_q.push_back(16'h0033);
    exp_q.push_back(16'h5544); exp_q.push_back(16'h0066);
    for (int i = 0; i < 4; i++) pop_chk("R4 packing");

    // R8/R11/R7 high-water level
    wr(2'd3, 16'h0100);
    wr(2'd1, 16'd1); wr(2'd2, 16'd7);
    start(1'b1);
    feed(8'h01); feed(8'h02); feed(8'h03); feed(8'h04);
    chk("R11 paused", card_rx_ready, 0);
    chk("R8 status flag", {dma_rx_req, stat_rx_level}, 2'b01);
    wr(2'd3, 16'h8100);
    chk("R7 R8 dma route", {dma_rx_req, stat_rx_level}, 2'b10);
    exp_q.push_back(16'h0201);
    pop_chk("R8 head");
    chk("R11 resumed", card_rx_ready, 1);
    chk("R8 below level", {dma_rx_req, stat_rx_level}, 2'b00);

    // R3/R12 block count write reloads byte counter
    wr(2'd3, 16'h1F00);
    wr(2'd1, 16'd3);
    start(1'b1);
    feed(8'hA1);
    wr(2'd2, 16'd0);
    feed(8'hA2); feed(8'hA3); feed(8'hA4);
    chk("R3 reload no done", done_cnt, 1);
    feed(8'hA5);
    chk("R3 done after reload", done_cnt, 2);
    exp_q.push_back(16'hA2A1); exp_q.push_back(16'hA4A3); exp_q.push_back(16'h00A5);
    for (int i = 0; i < 3; i++) pop_chk("R12 flushed contents");
    wr(2'd3, 16'h0000);
    chk("R12 R10 empty idle", {dma_rx_req, stat_rx_level, dma_tx_req, stat_tx_level}, 0);

    // R9/R5 host-to-card, odd block
    wr(2'd3, 16'h1F03);
    wr(2'd1, 16'd2); wr(2'd2, 16'd0);
    start(1'b0);
    chk("R9 status flag", {dma_tx_req, stat_tx_level}, 2'b01);
    wr(2'd3, 16'h1F83);
    chk("R9 dma route", {dma_tx_req, stat_tx_level}, 2'b10);
    wr(2'd3, 16'h1F03);
    wr(2'd0, 16'hBBAA); wr(2'd0, 16'h00CC);
    tx_q.push_back(8'hAA); tx_q.push_back(8'hBB); tx_q.push_back(8'hCC);
    card_tx_ready = 1'b1;
    for (int i = 0; i < 50; i++) begin
      if (!xfer_active) break;
      @(negedge clk);
    end
    card_tx_ready = 1'b0;
    chk("R5 byte count", tx_seen, 3);
    chk("R6 tx done", done_cnt, 3);
    chk("R10 idle quiet", {dma_rx_req, stat_rx_level, dma_tx_req, stat_tx_level, card_tx_valid}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule